// File: doc/BRIEF.md
# Change-Detect Interrupt Status Controller

This block watches five live status bits of a power-harvesting controller: harvest-count ready, open-circuit measurement ready, open-circuit measurement valid, shutdown status and wake status. It latches an interrupt bit whenever one of them changes, whether it rises or falls. The latched bits form an interrupt register that firmware reads. A single read strobe clears every latched bit at once. A status change that lands in the same cycle as the clearing read is kept, so it is not lost.

A per-source mask decides which latched bits may pull the shared interrupt line. The line is an active-low open-drain pull-down. When the discharge-mode configuration bit is set, the same line becomes a push-pull drive for an external source-discharge clamp. Its level then follows the operating mode: high in shutdown, low during an open-circuit measurement or sleep, and otherwise high only while the boost converter is enabled. The bus interface that produces the strobes is outside this block, and so is the analog clamp.

Top module: `intStatusCtrl`

## Requirements
- R1: After reset the interrupt register reads 0 and the pin is neither pulled low nor driven. Status values that are present when reset is released do not latch any bit.
- R2: When status bit k (4 harvest-ready, 3 open-circuit-ready, 2 open-circuit-valid, 1 shutdown, 0 wake) goes from 0 to 1, interrupt register bit k reads 1 after the next clock edge.
- R3: When a status bit goes from 1 to 0, its interrupt register bit is likewise set after the next clock edge.
- R4: A cycle with the read strobe high clears all latched interrupt bits together, effective after that clock edge.
- R5: A status change that coincides with the clearing read leaves its own interrupt bit set after that edge, while all the other bits are cleared.
- R6: Interrupt register bits 7 to 5 always read 0.
- R7: A mask bit of 1 stops its source from pulling the pin, but the interrupt bit is still latched and readable.
- R8: Outside discharge mode, the open-drain pull-down (odPullLow=1) is active exactly while some latched bit has a mask bit of 0. It releases once a read clears the bits.
- R9: A mask write loads maskWrData[4:0], with bit positions matching the interrupt register, at the clock edge of the write. The reset value of every mask bit is 0.
- R10: In discharge mode the open-drain pull-down is off and the push-pull drive is enabled. The drive level is 1 in shutdown, and shutdown takes priority over every other mode input.
- R11: In discharge mode, when the block is not in shutdown, the drive level is 0 while an open-circuit measurement or sleep is in progress.
- R12: In discharge mode, when the block is not in shutdown, measurement or sleep, the drive level equals the boost-enable input.
- R13: While the status bits hold steady, no new interrupt bit is latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| statusIn | input | 5 | Live status bits, positions as in R2 |
| maskWrEn | input | 1 | Mask register write strobe |
| maskWrData | input | 5 | Mask value to load |
| intRdStrobe | input | 1 | Interrupt register read, clears all bits |
| discMode | input | 1 | 1 selects the push-pull source-discharge pin mode |
| inShutdown | input | 1 | Block is in shutdown |
| inVocMeas | input | 1 | Open-circuit measurement in progress |
| inSleep | input | 1 | Low-light sleep active |
| boostEn | input | 1 | Boost converter enabled |
| intReg | output | 8 | Interrupt register value |
| odPullLow | output | 1 | Open-drain pull-down enable, which asserts the interrupt |
| ppEnable | output | 1 | Push-pull drive enable in discharge mode |
| ppLevel | output | 1 | Push-pull drive level |

## Verification
The change detector is tested with single rising edges and single falling edges on different bit positions. It is also tested with changes arriving on successive cycles on top of bits that are already latched, which separates true edge detection from level sensing and from bits overwriting each other. A change placed in the same cycle as the clearing read tells a design that gives the new event priority from one that drops it. Masked and unmasked sources are latched together to show that the mask gates only the pin and not the register. The discharge-mode pin is walked through every combination of shutdown, measurement, sleep and boost that has its own priority.

// File: rtl/intPkg.sv
package intPkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic detectEn;  // edge detection armed
    logic clearAll;  // read of interrupt register
    logic maskLoad;  // mask register write
  } intStrobe_t;

  typedef enum logic [1:0] {
    PIN_OPEN_DRAIN = 2'd0,
    PIN_DISC_HIGH  = 2'd1,
    PIN_DISC_OFF   = 2'd2,
    PIN_DISC_BOOST = 2'd3
  } pinMode_t;
endpackage

// File: rtl/intDatapath.sv
module intDatapath
  import intPkg::*;
#(
  parameter int NUM_SRC = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  intStrobe_t         strobes,
  input  logic [NUM_SRC-1:0] statusIn,
  input  logic [NUM_SRC-1:0] maskWrData,
  output logic [NUM_SRC-1:0] latchQ,
  output logic               anyPending
);
  logic [NUM_SRC-1:0] statusQ;
  logic [NUM_SRC-1:0] maskQ;
  logic [NUM_SRC-1:0] edgeHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= '0;
      maskQ   <= '0;
    end else begin
      statusQ <= statusIn;
      if (strobes.maskLoad) maskQ <= maskWrData;
    end
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    assign edgeHit[i] = strobes.detectEn & (statusIn[i] ^ statusQ[i]);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                latchQ[i] <= 1'b0;
      else if (strobes.clearAll) latchQ[i] <= edgeHit[i];
      else                      latchQ[i] <= latchQ[i] | edgeHit[i];
    end
  end

  assign anyPending = |(latchQ & ~maskQ);
endmodule

// File: rtl/intControl.sv
module intControl
  import intPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       intRdStrobe,
  input  logic       maskWrEn,
  input  logic       anyPending,
  input  logic       discMode,
  input  logic       inShutdown,
  input  logic       inVocMeas,
  input  logic       inSleep,
  input  logic       boostEn,
  output intStrobe_t strobes,
  output logic       odPullLow,
  output logic       ppEnable,
  output logic       ppLevel
);
  logic     primedQ;
  pinMode_t pinMode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) primedQ <= 1'b0;
    else       primedQ <= 1'b1;
  end

  assign strobes.detectEn = primedQ;
  assign strobes.clearAll = intRdStrobe;
  assign strobes.maskLoad = maskWrEn;

  always_comb begin
    if (!discMode)               pinMode = PIN_OPEN_DRAIN;
    else if (inShutdown)         pinMode = PIN_DISC_HIGH;
    else if (inVocMeas || inSleep) pinMode = PIN_DISC_OFF;
    else                         pinMode = PIN_DISC_BOOST;
  end

  always_comb begin
    odPullLow = 1'b0;
    ppEnable  = 1'b1;
    ppLevel   = 1'b0;
    unique case (pinMode)
      PIN_OPEN_DRAIN: begin
        ppEnable  = 1'b0;
        odPullLow = anyPending;
      end
      PIN_DISC_HIGH:  ppLevel = 1'b1;
      PIN_DISC_OFF:   ppLevel = 1'b0;
      PIN_DISC_BOOST: ppLevel = boostEn;
      default:        ppLevel = 1'b0;
    endcase
  end
endmodule

// File: rtl/intStatusCtrl.sv
module intStatusCtrl
  import intPkg::*;
#(
  parameter int NUM_SRC = 5,
  parameter int REG_W   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] statusIn,
  input  logic               maskWrEn,
  input  logic [NUM_SRC-1:0] maskWrData,
  input  logic               intRdStrobe,
  input  logic               discMode,
  input  logic               inShutdown,
  input  logic               inVocMeas,
  input  logic               inSleep,
  input  logic               boostEn,
  output logic [REG_W-1:0]   intReg,
  output logic               odPullLow,
  output logic               ppEnable,
  output logic               ppLevel
);
  localparam int PAD_W = REG_W - NUM_SRC;

  intStrobe_t         strobes;
  logic [NUM_SRC-1:0] latchQ;
  logic               anyPending;

  intControl u_ctrl (
    .clk(clk), .rstN(rstN), .intRdStrobe(intRdStrobe), .maskWrEn(maskWrEn),
    .anyPending(anyPending), .discMode(discMode), .inShutdown(inShutdown),
    .inVocMeas(inVocMeas), .inSleep(inSleep), .boostEn(boostEn),
    .strobes(strobes), .odPullLow(odPullLow), .ppEnable(ppEnable), .ppLevel(ppLevel)
  );

  intDatapath #(.NUM_SRC(NUM_SRC)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .statusIn(statusIn),
    .maskWrData(maskWrData), .latchQ(latchQ), .anyPending(anyPending)
  );

  assign intReg = {{PAD_W{1'b0}}, latchQ};
endmodule

// File: rtl/intStatusChk.sv
module intStatusChk #(
  parameter int NUM_SRC = 5,
  parameter int REG_W   = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] statusIn,
  input logic               maskWrEn,
  input logic [NUM_SRC-1:0] maskWrData,
  input logic               intRdStrobe,
  input logic               discMode,
  input logic               inShutdown,
  input logic               inVocMeas,
  input logic               inSleep,
  input logic               boostEn,
  input logic [REG_W-1:0]   intReg,
  input logic               odPullLow,
  input logic               ppEnable,
  input logic               ppLevel
);
  logic               armedQ;
  logic [NUM_SRC-1:0] prevStatusQ;
  logic [NUM_SRC-1:0] shadowMaskQ;
  logic [NUM_SRC-1:0] chgQ;
  logic [NUM_SRC-1:0] chg;

  assign chg = statusIn ^ prevStatusQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armedQ      <= 1'b0;
      prevStatusQ <= '0;
      shadowMaskQ <= '0;
      chgQ        <= '0;
    end else begin
      armedQ      <= 1'b1;
      prevStatusQ <= statusIn;
      chgQ        <= armedQ ? chg : '0;
      if (maskWrEn) shadowMaskQ <= maskWrData;
    end
  end

  // R6
  p_reserved_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    intReg[REG_W-1:NUM_SRC] == '0);

  // R2 and R3: any change latches its bit on the next edge
  p_change_latched_r2: assert property (@(posedge clk) disable iff (!rstN)
    (armedQ && chg != '0) |=> ((intReg[NUM_SRC-1:0] & chgQ) == chgQ));

  // R4
  p_read_clears_r4: assert property (@(posedge clk) disable iff (!rstN)
    (armedQ && intRdStrobe && chg == '0) |=> (intReg[NUM_SRC-1:0] == '0));

  // R8
  p_pin_pending_r8: assert property (@(posedge clk) disable iff (!rstN)
    !discMode |-> (odPullLow == |(intReg[NUM_SRC-1:0] & ~shadowMaskQ)) && !ppEnable);

  // R10
  p_disc_shutdown_r10: assert property (@(posedge clk) disable iff (!rstN)
    (discMode && inShutdown) |-> (ppEnable && ppLevel && !odPullLow));

  // R11
  p_disc_off_r11: assert property (@(posedge clk) disable iff (!rstN)
    (discMode && !inShutdown && (inVocMeas || inSleep)) |-> !ppLevel);

  // R12
  p_disc_boost_r12: assert property (@(posedge clk) disable iff (!rstN)
    (discMode && !inShutdown && !inVocMeas && !inSleep) |-> (ppLevel == boostEn));
endmodule

bind intStatusCtrl intStatusChk #(.NUM_SRC(NUM_SRC), .REG_W(REG_W)) u_chk (
  .clk(clk), .rstN(rstN), .statusIn(statusIn), .maskWrEn(maskWrEn),
  .maskWrData(maskWrData), .intRdStrobe(intRdStrobe), .discMode(discMode),
  .inShutdown(inShutdown), .inVocMeas(inVocMeas), .inSleep(inSleep),
  .boostEn(boostEn), .intReg(intReg), .odPullLow(odPullLow),
  .ppEnable(ppEnable), .ppLevel(ppLevel)
);

// File: tb/sim_intStatusCtrl.sv
`timescale 1ns/1ps
module sim_intStatusCtrl;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [4:0] statusIn = 5'b0;
  logic       maskWrEn = 1'b0;
  logic [4:0] maskWrData = 5'b0;
  logic       intRdStrobe = 1'b0;
  logic       discMode = 1'b0;
  logic       inShutdown = 1'b0;
  logic       inVocMeas = 1'b0;
  logic       inSleep = 1'b0;
  logic       boostEn = 1'b0;
  logic [7:0] intReg;
  logic       odPullLow, ppEnable, ppLevel;

  int errors = 0;
  int checks = 0;
  logic [4:0] st = 5'b0;

  always #5 clk = ~clk;

  intStatusCtrl u0 (
    .clk(clk), .rstN(rstN), .statusIn(statusIn), .maskWrEn(maskWrEn),
    .maskWrData(maskWrData), .intRdStrobe(intRdStrobe), .discMode(discMode),
    .inShutdown(inShutdown), .inVocMeas(inVocMeas), .inSleep(inSleep),
    .boostEn(boostEn), .intReg(intReg), .odPullLow(odPullLow),
    .ppEnable(ppEnable), .ppLevel(ppLevel)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic toggle(input logic [4:0] m);
    st = st ^ m;
    statusIn = st;
    @(negedge clk);
  endtask

  task automatic readClear();
    intRdStrobe = 1'b1;
    @(negedge clk);
    intRdStrobe = 1'b0;
  endtask

  task automatic testReset();
    st = 5'b00011;
    statusIn = st;
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 reg", intReg, 8'h00);
    chk("R1 pin", {5'b0, odPullLow, ppEnable, ppLevel}, 8'h00);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 no latch at release", intReg, 8'h00);
    chk("R1 pin idle", {7'b0, odPullLow}, 8'h00);
  endtask

  task automatic testRise();
    toggle(5'b10000);
    chk("R2 rise bit4", intReg, 8'h10);
    chk("R8 pin asserted", {7'b0, odPullLow}, 8'h01);
    @(negedge clk);
    chk("R13 stable", intReg, 8'h10);
    readClear();
    chk("R4 cleared", intReg, 8'h00);
    chk("R8 pin released", {7'b0, odPullLow}, 8'h00);
  endtask

  task automatic testFall();
    toggle(5'b00001);
    chk("R3 fall bit0", intReg, 8'h01);
    readClear();
    chk("R4 cleared", intReg, 8'h00);
  endtask

  task automatic testMulti();
    toggle(5'b00100);
    chk("R2 bit2", intReg, 8'h04);
    toggle(5'b01000);
    chk("R2 accumulate bit3", intReg, 8'h0C);
    chk("R6 upper zero", {5'b0, intReg[7:5]}, 8'h00);
    readClear();
    chk("R4 clear all", intReg, 8'h00);
  endtask

  task automatic testRace();
    toggle(5'b00010);
    chk("R3 bit1", intReg, 8'h02);
    intRdStrobe = 1'b1;
    st = st ^ 5'b01000;
    statusIn = st;
    @(negedge clk);
    intRdStrobe = 1'b0;
    chk("R5 kept on read", intReg, 8'h08);
    readClear();
    chk("R4 cleared", intReg, 8'h00);
  endtask

  task automatic testMask();
    maskWrEn = 1'b1;
    maskWrData = 5'b01000;
    @(negedge clk);
    maskWrEn = 1'b0;
    maskWrData = 5'b0;
    toggle(5'b01000);
    chk("R7 masked still latched", intReg, 8'h08);
    chk("R7 masked pin", {7'b0, odPullLow}, 8'h00);
    toggle(5'b00001);
    chk("R7 both latched", intReg, 8'h09);
    chk("R8 unmasked pin", {7'b0, odPullLow}, 8'h01);
    readClear();
    maskWrEn = 1'b1;
    @(negedge clk);
    maskWrEn = 1'b0;
    toggle(5'b01000);
    chk("R9 unmask reload", {7'b0, odPullLow}, 8'h01);
    readClear();
    chk("R4 cleared", intReg, 8'h00);
  endtask

  task automatic testDisc();
    toggle(5'b00100);
    discMode = 1'b1;
    inShutdown = 1'b1;
    inSleep = 1'b1;
    @(negedge clk);
    chk("R10 od off", {7'b0, odPullLow}, 8'h00);
    chk("R10 shutdown high", {6'b0, ppEnable, ppLevel}, 8'h03);
    inShutdown = 1'b0;
    @(negedge clk);
    chk("R11 sleep low", {6'b0, ppEnable, ppLevel}, 8'h02);
    inSleep = 1'b0;
    inVocMeas = 1'b1;
    boostEn = 1'b1;
    @(negedge clk);
    chk("R11 meas low", {7'b0, ppLevel}, 8'h00);
    inVocMeas = 1'b0;
    @(negedge clk);
    chk("R12 boost on", {7'b0, ppLevel}, 8'h01);
    boostEn = 1'b0;
    @(negedge clk);
    chk("R12 boost off", {7'b0, ppLevel}, 8'h00);
    discMode = 1'b0;
    @(negedge clk);
    chk("R10 back to open drain", {6'b0, odPullLow, ppEnable}, 8'h02);
    readClear();
    chk("R4 cleared", intReg, 8'h00);
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    @(negedge clk);
    testReset();
    testRise();
    testFall();
    testMulti();
    testRace();
    testMask();
    testDisc();
    finishRun();
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    finishRun();
  end
endmodule